// File: doc/BRIEF.md
# Round-Robin Voice Sequencer

This block schedules a single shared sample-playback datapath across a set of voices. It visits them one after another, in a fixed circular order. Each accepted E-clock event does two things. It issues one sample-memory fetch for the current voice and fetch slot, and it steps the slot. Every voice receives two fetches at consecutive integer addresses, slot 0 and then slot 1. After its second fetch the voice is updated, and the sequencer moves on to the next voice. Two E events therefore make one voice period.

The frame ends on the voice whose index equals the active limit. The sequencer then returns to voice 0 and pulses an end-of-frame flag. The active limit is taken from a runtime-programmable count, clamped to the highest voice index. It is loaded during reset and at each wrap, and at no other time.

The per-voice accumulator integer part, channel-assign field and processed sample are supplied from outside for the voice on `voice_idx`. On every update the sample is latched into one of sixteen output channel slots, chosen by the channel-assign field.

Fetches leave on a valid/ready stream. A request stays valid with a constant payload until `fetch_ready` is seen high. An E event that arrives while a request is valid and not ready is dropped. A dropped event moves nothing. When `fetch_ready` is high, an E event in the same cycle replaces the completing request, so requests can run back to back.

Top module: `voice_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the following are cleared: `voice_idx`, `slot_idx`, `fetch_valid`, `upd_strobe`, `frame_end`, `upd_voice`, the fetch payload and all channel slots.
- R2: An accepted E event is `e_tick` high while `fetch_valid` is low or `fetch_ready` is high. Each accepted event raises `fetch_valid` on the next cycle, with these fields:
  - `fetch_voice` = the current voice.
  - `fetch_slot` = the current slot.
  - `fetch_bank` = bits [2:0] of `voice_chan`.
  - `fetch_addr` = (`voice_accum` + slot) modulo 2^ADDR_W.
- R3: The slot alternates 0, 1 on successive accepted events. The event taken in slot 1 returns the slot to 0. On the next cycle `upd_strobe` is high for exactly one cycle, and `upd_voice` holds the voice that was updated.
- R4: An update advances the voice index by one. The exception is when the index equals the active limit: the index then returns to 0, and `frame_end` pulses for one cycle together with `upd_strobe`.
- R5: The active limit equals `active_count` when that value is below NUM_VOICES-1, and NUM_VOICES-1 otherwise. `voice_idx` never exceeds NUM_VOICES-1.
- R6: `active_count` is sampled only during reset and on a wrap. A change made in mid-frame first alters the length of the following frame.
- R7: On an update, channel slot `voice_chan` (4 bits) takes `voice_sample`. Slots that are not selected keep their values.
- R8: While `fetch_valid` is high and `fetch_ready` is low, the request and its payload are held. E events in those cycles change neither `voice_idx` nor `slot_idx`.
- R9: A valid request seen with `fetch_ready` high and no `e_tick` is retired: `fetch_valid` is low on the next cycle. With `e_tick` high in that cycle, `fetch_valid` stays high.
- R10: `frame_end` is never high without `upd_strobe`. Two updates are never on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| e_tick | input | 1 | One-cycle E-clock event strobe |
| active_count | input | ACT_W | Requested highest voice index |
| voice_accum | input | ADDR_W | Accumulator integer part of the voice on `voice_idx` |
| voice_chan | input | CA_W | Channel-assign field of the voice on `voice_idx` |
| voice_sample | input | SMP_W | Processed output of the voice on `voice_idx` |
| fetch_ready | input | 1 | Memory accepts the fetch request |
| fetch_valid | output | 1 | Fetch request present |
| fetch_addr | output | ADDR_W | Sample address |
| fetch_voice | output | VOICE_W | Voice of the request |
| fetch_bank | output | BANK_W | Bank select |
| fetch_slot | output | 1 | Fetch slot, 0 or 1 |
| voice_idx | output | VOICE_W | Current voice |
| slot_idx | output | 1 | Current fetch slot |
| upd_strobe | output | 1 | Voice-update pulse |
| upd_voice | output | VOICE_W | Voice of the last update |
| frame_end | output | 1 | End-of-frame pulse |
| chan_out | output | NUM_CH*SMP_W | Channel slots, channel k in bits [k*SMP_W +: SMP_W] |

## Verification
The bench builds the block with the full 25 voices and 16 channel slots, which makes the clamp of an oversized count to 24 and a complete 25-voice frame observable. ADDR_W is narrowed to 10, so one voice's accumulator sits at 1023 and its slot-1 fetch wraps to address 0. All channel-assign values are even and some have bit 3 set. This lets the bench check, in the same run, that bit 3 is removed from the bank select and that odd channel slots stay untouched.

// File: rtl/vseq_pkg.sv
`timescale 1ns/1ps
package vseq_pkg;
  // Fetch slot of the current voice: first or second read of the pair.
  typedef enum logic {
    SLOT_FIRST  = 1'b0,
    SLOT_SECOND = 1'b1
  } slot_e;
endpackage

// File: rtl/vseq_stepper.sv
`timescale 1ns/1ps
module vseq_stepper
  import vseq_pkg::*;
#(
  parameter int NUM_VOICES = 25,
  parameter int ACT_W      = 5,
  parameter int VOICE_W    = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               advance_i,
  input  logic [ACT_W-1:0]   act_i,
  output logic [VOICE_W-1:0] voice_o,
  output slot_e              slot_o,
  output logic               upd_o,
  output logic [VOICE_W-1:0] upd_voice_o,
  output logic               end_o
);
  localparam int LAST = NUM_VOICES - 1;

  logic [VOICE_W-1:0] voice_q, lim_q, lim_nxt, upd_voice_q;
  slot_e              slot_q;
  logic               upd_q, end_q;
  logic               upd_now, wrap_now;

  // Clamp the requested count to the highest existing voice.
  always_comb begin
    if (int'(act_i) > LAST) lim_nxt = VOICE_W'(LAST);
    else                    lim_nxt = VOICE_W'(act_i);
  end

  assign upd_now  = advance_i && (slot_q == SLOT_SECOND);
  assign wrap_now = upd_now && (voice_q >= lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      voice_q     <= '0;
      slot_q      <= SLOT_FIRST;
      upd_q       <= 1'b0;
      end_q       <= 1'b0;
      upd_voice_q <= '0;
      lim_q       <= lim_nxt;
    end else begin
      upd_q <= upd_now;
      end_q <= wrap_now;
      if (advance_i) begin
        if (slot_q == SLOT_FIRST) begin
          slot_q <= SLOT_SECOND;
        end else begin
          slot_q      <= SLOT_FIRST;
          upd_voice_q <= voice_q;
          if (wrap_now) begin
            voice_q <= '0;
            lim_q   <= lim_nxt;
          end else begin
            voice_q <= voice_q + 1'b1;
          end
        end
      end
    end
  end

  assign voice_o     = voice_q;
  assign slot_o      = slot_q;
  assign upd_o       = upd_q;
  assign upd_voice_o = upd_voice_q;
  assign end_o       = end_q;
endmodule

// File: rtl/vseq_fetch_port.sv
`timescale 1ns/1ps
module vseq_fetch_port
  import vseq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CA_W    = 4,
  parameter int BANK_W  = 3,
  parameter int VOICE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept_i,
  input  logic               ready_i,
  input  logic [ADDR_W-1:0]  accum_i,
  input  logic [CA_W-1:0]    ca_i,
  input  logic [VOICE_W-1:0] voice_i,
  input  slot_e              slot_i,
  output logic               valid_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [VOICE_W-1:0] voice_o,
  output logic [BANK_W-1:0]  bank_o,
  output logic               slot_o
);
  logic [ADDR_W-1:0] slot_ext;
  assign slot_ext = {{(ADDR_W-1){1'b0}}, slot_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      voice_o <= '0;
      bank_o  <= '0;
      slot_o  <= 1'b0;
    end else if (accept_i) begin
      // Natural ADDR_W-bit wrap of the integer address.
      valid_o <= 1'b1;
      addr_o  <= accum_i + slot_ext;
      voice_o <= voice_i;
      bank_o  <= ca_i[BANK_W-1:0];
      slot_o  <= slot_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vseq_chan_bank.sv
`timescale 1ns/1ps
module vseq_chan_bank #(
  parameter int NUM_CH = 16,
  parameter int SMP_W  = 16,
  parameter int CA_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we_i,
  input  logic [CA_W-1:0]         sel_i,
  input  logic [SMP_W-1:0]        data_i,
  output logic [NUM_CH*SMP_W-1:0] chan_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [SMP_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst)                                 slot_q <= '0;
      else if (we_i && (sel_i == CA_W'(g)))    slot_q <= data_i;
    end
    assign chan_o[g*SMP_W +: SMP_W] = slot_q;
  end
endmodule

// File: rtl/voice_sequencer.sv
`timescale 1ns/1ps
module voice_sequencer
  import vseq_pkg::*;
#(
  parameter int NUM_VOICES = 25,
  parameter int ACT_W      = 5,
  parameter int ADDR_W     = 16,
  parameter int NUM_CH     = 16,
  parameter int SMP_W      = 16,
  parameter int BANK_W     = 3,
  parameter int VOICE_W    = $clog2(NUM_VOICES),
  parameter int CA_W       = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    e_tick,
  input  logic [ACT_W-1:0]        active_count,
  input  logic [ADDR_W-1:0]       voice_accum,
  input  logic [CA_W-1:0]         voice_chan,
  input  logic [SMP_W-1:0]        voice_sample,
  input  logic                    fetch_ready,
  output logic                    fetch_valid,
  output logic [ADDR_W-1:0]       fetch_addr,
  output logic [VOICE_W-1:0]      fetch_voice,
  output logic [BANK_W-1:0]       fetch_bank,
  output logic                    fetch_slot,
  output logic [VOICE_W-1:0]      voice_idx,
  output logic                    slot_idx,
  output logic                    upd_strobe,
  output logic [VOICE_W-1:0]      upd_voice,
  output logic                    frame_end,
  output logic [NUM_CH*SMP_W-1:0] chan_out
);
  slot_e cur_slot;
  logic  accept;
  logic  write_now;

  // An event is taken unless a request is stalled at the edge.
  assign accept    = e_tick && (!fetch_valid || fetch_ready);
  assign write_now = accept && (cur_slot == SLOT_SECOND);

  vseq_stepper #(
    .NUM_VOICES(NUM_VOICES),
    .ACT_W     (ACT_W),
    .VOICE_W   (VOICE_W)
  ) u_step (
    .clk        (clk),
    .rst        (rst),
    .advance_i  (accept),
    .act_i      (active_count),
    .voice_o    (voice_idx),
    .slot_o     (cur_slot),
    .upd_o      (upd_strobe),
    .upd_voice_o(upd_voice),
    .end_o      (frame_end)
  );

  vseq_fetch_port #(
    .ADDR_W (ADDR_W),
    .CA_W   (CA_W),
    .BANK_W (BANK_W),
    .VOICE_W(VOICE_W)
  ) u_fetch (
    .clk     (clk),
    .rst     (rst),
    .accept_i(accept),
    .ready_i (fetch_ready),
    .accum_i (voice_accum),
    .ca_i    (voice_chan),
    .voice_i (voice_idx),
    .slot_i  (cur_slot),
    .valid_o (fetch_valid),
    .addr_o  (fetch_addr),
    .voice_o (fetch_voice),
    .bank_o  (fetch_bank),
    .slot_o  (fetch_slot)
  );

  vseq_chan_bank #(
    .NUM_CH(NUM_CH),
    .SMP_W (SMP_W),
    .CA_W  (CA_W)
  ) u_chan (
    .clk   (clk),
    .rst   (rst),
    .we_i  (write_now),
    .sel_i (voice_chan),
    .data_i(voice_sample),
    .chan_o(chan_out)
  );

  assign slot_idx = cur_slot;
endmodule

// File: rtl/vseq_chk.sv
`timescale 1ns/1ps
module vseq_chk #(
  parameter int NUM_VOICES = 25,
  parameter int ADDR_W     = 16,
  parameter int VOICE_W    = 5,
  parameter int BANK_W     = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               e_tick,
  input logic               fetch_ready,
  input logic               fetch_valid,
  input logic [ADDR_W-1:0]  fetch_addr,
  input logic [VOICE_W-1:0] fetch_voice,
  input logic [BANK_W-1:0]  fetch_bank,
  input logic               fetch_slot,
  input logic [VOICE_W-1:0] voice_idx,
  input logic               slot_idx,
  input logic               upd_strobe,
  input logic               frame_end
);
  localparam int LAST = NUM_VOICES - 1;

  AST_EVENT_ISSUES: assert property (@(posedge clk) disable iff (rst)
    e_tick && (!fetch_valid || fetch_ready) |=> fetch_valid); // R2

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |=> !upd_strobe); // R3

  AST_UPD_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |-> (slot_idx == 1'b0)); // R3

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (voice_idx == '0)); // R4

  AST_VOICE_CAP: assert property (@(posedge clk) disable iff (rst)
    int'(voice_idx) <= LAST); // R5

  AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (rst)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr)
      && $stable(fetch_voice) && $stable(fetch_bank) && $stable(fetch_slot)); // R8

  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (rst)
    fetch_valid && !fetch_ready |=> $stable(voice_idx) && $stable(slot_idx)); // R8

  AST_IDLE_RETIRES: assert property (@(posedge clk) disable iff (rst)
    fetch_valid && fetch_ready && !e_tick |=> !fetch_valid); // R9

  AST_END_NEEDS_UPD: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> upd_strobe); // R10
endmodule

bind voice_sequencer vseq_chk #(
  .NUM_VOICES(NUM_VOICES),
  .ADDR_W    (ADDR_W),
  .VOICE_W   (VOICE_W),
  .BANK_W    (BANK_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .e_tick     (e_tick),
  .fetch_ready(fetch_ready),
  .fetch_valid(fetch_valid),
  .fetch_addr (fetch_addr),
  .fetch_voice(fetch_voice),
  .fetch_bank (fetch_bank),
  .fetch_slot (fetch_slot),
  .voice_idx  (voice_idx),
  .slot_idx   (slot_idx),
  .upd_strobe (upd_strobe),
  .frame_end  (frame_end)
);

// File: tb/voice_sequencer_bench.sv
`timescale 1ns/1ps
module voice_sequencer_bench;
  localparam int NV    = 25;
  localparam int LASTV = NV - 1;
  localparam int AW    = 10;
  localparam int NCH   = 16;
  localparam int SW    = 16;
  localparam int VW    = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              e_tick = 1'b0;
  logic [4:0]        active_count = 5'd3;
  logic [AW-1:0]     voice_accum = '0;
  logic [3:0]        voice_chan = '0;
  logic [SW-1:0]     voice_sample = '0;
  logic              fetch_ready = 1'b1;
  logic              fetch_valid;
  logic [AW-1:0]     fetch_addr;
  logic [VW-1:0]     fetch_voice;
  logic [2:0]        fetch_bank;
  logic              fetch_slot;
  logic [VW-1:0]     voice_idx;
  logic              slot_idx;
  logic              upd_strobe;
  logic [VW-1:0]     upd_voice;
  logic              frame_end;
  logic [NCH*SW-1:0] chan_out;

  always #10 clk = ~clk;

  voice_sequencer #(.NUM_VOICES(NV), .ADDR_W(AW), .NUM_CH(NCH), .SMP_W(SW)) u_voice_sequencer (
    .clk(clk), .rst(rst), .e_tick(e_tick), .active_count(active_count),
    .voice_accum(voice_accum), .voice_chan(voice_chan), .voice_sample(voice_sample),
    .fetch_ready(fetch_ready), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_voice(fetch_voice), .fetch_bank(fetch_bank), .fetch_slot(fetch_slot),
    .voice_idx(voice_idx), .slot_idx(slot_idx), .upd_strobe(upd_strobe),
    .upd_voice(upd_voice), .frame_end(frame_end), .chan_out(chan_out)
  );

  int checks = 0;
  int fails = 0;
  int ncyc = 0;
  int act_v = 3;
  bit done = 0;
  int acc[NV];
  int ca_arr[NV];
  int flen[$];
  int upd_cnt = 0;
  int wrap_seen = 0;

  // Reference model state
  int m_voice, m_slot, m_lim, m_fv, m_addr, m_fvoice, m_bank, m_fslot;
  int m_upd, m_updv, m_end;
  int m_ch[NCH];

  task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, ncyc);
    end
  endtask

  task automatic model_step(bit rs, bit e, bit rdy, int act, int acc_in, int ca_in, int smp_in);
    bit take;
    if (rs) begin
      m_voice = 0; m_slot = 0; m_fv = 0; m_addr = 0; m_fvoice = 0; m_bank = 0; m_fslot = 0;
      m_upd = 0; m_updv = 0; m_end = 0;
      m_lim = (act > LASTV) ? LASTV : act;
      for (int k = 0; k < NCH; k++) m_ch[k] = 0;
      return;
    end
    m_upd = 0;
    m_end = 0;
    take = e && (!m_fv || rdy);
    if (take) begin
      m_fv = 1;
      m_addr = (acc_in + m_slot) % (1 << AW);
      m_fvoice = m_voice;
      m_bank = ca_in % 8;
      m_fslot = m_slot;
      if (m_slot == 0) m_slot = 1;
      else begin
        m_slot = 0;
        m_upd = 1;
        m_updv = m_voice;
        m_ch[ca_in] = smp_in;
        if (m_voice >= m_lim) begin
          m_voice = 0;
          m_end = 1;
          m_lim = (act > LASTV) ? LASTV : act;
        end else m_voice++;
      end
    end else if (m_fv && rdy) m_fv = 0;
  endtask

  task automatic compare_all();
    cmp("R4", "voice_idx", voice_idx, m_voice);
    cmp("R3", "slot_idx", slot_idx, m_slot);
    cmp("R3", "upd_strobe", upd_strobe, m_upd);
    cmp("R3", "upd_voice", upd_voice, m_updv);
    cmp("R4", "frame_end", frame_end, m_end);
    cmp("R8", "fetch_valid", fetch_valid, m_fv);
    if (m_fv != 0) begin
      cmp("R2", "fetch_addr", fetch_addr, m_addr);
      cmp("R2", "fetch_voice", fetch_voice, m_fvoice);
      cmp("R2", "fetch_bank", fetch_bank, m_bank);
      cmp("R2", "fetch_slot", fetch_slot, m_fslot);
    end
    for (int k = 0; k < NCH; k++)
      cmp("R7", "chan_out", chan_out[k*SW +: SW], m_ch[k]);
  endtask

  task automatic cyc(bit rs, bit e, bit rdy);
    int v = m_voice;
    int smp = (v * 641 + ncyc * 13) % 65536;
    rst = rs;
    e_tick = e;
    fetch_ready = rdy;
    active_count = 5'(act_v);
    voice_accum = AW'(acc[v]);
    voice_chan = 4'(ca_arr[v]);
    voice_sample = SW'(smp);
    model_step(rs, e, rdy, act_v, acc[v], ca_arr[v], smp);
    @(posedge clk);
    @(negedge clk);
    ncyc++;
    compare_all();
    if (rs) upd_cnt = 0;
    else begin
      if (upd_strobe) upd_cnt++;
      if (frame_end) begin
        flen.push_back(upd_cnt);
        upd_cnt = 0;
        if (!upd_strobe) cmp("R10", "frame_end without update", 1, 0);
      end
      if (fetch_valid && fetch_voice == 5'd4 && fetch_slot) begin
        wrap_seen++;
        cmp("R2", "wrapped address", fetch_addr, 0);
      end
    end
  endtask

  task automatic check_frames(string req, int exp[$]);
    cmp(req, "frame count", flen.size(), exp.size());
    for (int k = 0; k < exp.size() && k < flen.size(); k++)
      cmp(req, "frame length", flen[k], exp[k]);
    flen.delete();
  endtask

  initial begin
    int sv, ss, sa;
    for (int v = 0; v < NV; v++) begin
      acc[v] = (v * 97 + 900) % (1 << AW);
      ca_arr[v] = (v * 6) % NCH;
    end
    acc[4] = (1 << AW) - 1;
    @(negedge clk);
    repeat (3) cyc(1, 0, 1);
    cmp("R1", "voice_idx", voice_idx, 0);
    cmp("R1", "slot_idx", slot_idx, 0);
    cmp("R1", "fetch_valid", fetch_valid, 0);
    cmp("R1", "upd_strobe", upd_strobe, 0);
    cmp("R1", "frame_end", frame_end, 0);
    cmp("R1", "chan_out", chan_out, 0);

    // Continuous events, limit 3: three frames of four voices
    repeat (24) cyc(0, 1, 1);
    check_frames("R4", '{4, 4, 4});

    // Mid-frame change of the count only counts after the wrap
    repeat (3) cyc(0, 1, 1);
    act_v = 1;
    repeat (13) cyc(0, 1, 1);
    check_frames("R6", '{4, 2, 2});

    // Oversized count is clamped to the last voice
    act_v = 31;
    repeat (4) cyc(0, 1, 1);
    repeat (50) cyc(0, 1, 1);
    check_frames("R5", '{2, 25});
    cmp("R2", "address wrap observed", (wrap_seen > 0), 1);

    // Mixed events and back-pressure
    act_v = 5;
    for (int i = 0; i < 300; i++) cyc(0, (i % 2 == 0) || (i % 5 == 0), (i % 3 != 0));
    flen.delete();

    // Explicit stall: events while stalled move nothing
    cyc(0, 0, 1);
    cyc(0, 1, 0);
    cmp("R8", "request raised", fetch_valid, 1);
    sv = voice_idx; ss = slot_idx; sa = fetch_addr;
    repeat (5) cyc(0, 1, 0);
    cmp("R8", "voice frozen", voice_idx, sv);
    cmp("R8", "slot frozen", slot_idx, ss);
    cmp("R8", "payload held", fetch_addr, sa);
    cmp("R8", "still valid", fetch_valid, 1);
    cyc(0, 0, 1);
    cmp("R9", "retired", fetch_valid, 0);
    cyc(0, 1, 1);
    cmp("R9", "valid after event", fetch_valid, 1);
    cyc(0, 1, 1);
    cmp("R9", "back-to-back valid", fetch_valid, 1);
    cmp("R9", "slot after two events", slot_idx, ss);

    // Even channel-assign values only: odd slots stay zero
    for (int k = 1; k < NCH; k += 2) cmp("R7", "unselected slot", chan_out[k*SW +: SW], 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule